// File: doc/BRIEF.md
# Platform Interrupt Controller Core

This block gathers a vector of external interrupt requests and hands them to a set of independent processor contexts. Every source passes through a gateway. The gateway turns a level or a rising edge into a single pending bit. Each source also carries a programmable priority. Each context holds its own enable mask and priority threshold. From the sources that are pending, enabled for it and above its threshold, each context picks the best one and raises its interrupt line while one exists.

Software reaches the block through a plain register port. The port carries a write strobe, a read strobe, an address and data. Reading a context's claim word returns the identifier of the winning source for that context. The same read clears that source's pending bit, and the gateway then holds the source off until a completion arrives. Writing the identifier back to the same word releases the gateway again. Sources are numbered from 1, and identifier 0 means that nothing is waiting.

Top module: `intc_core`

## Requirements
- R1: After reset, every priority, enable mask and threshold reads 0, every context line is low and every claim read returns 0.
- R2: Context line c is high exactly when some source is pending, enabled in context c's mask and has a priority strictly above context c's threshold.
- R3: A source with priority 0 never reaches any context. A source whose priority equals a context's threshold is masked for that context. A claim with nothing eligible returns 0.
- R4: A claim returns the eligible source with the highest priority. When priorities tie, it returns the one with the lowest identifier.
- R5: Enable masks and thresholds act per context, so one source can be eligible for one context and masked for another at the same time.
- R6: A claim read clears the returned source's pending bit within the same clock edge, so no context is offered that source again until it becomes pending anew.
- R7: A claimed source stays blocked until a write of its identifier to a claim word. A completion carrying the identifier of a source that is not in service has no effect.
- R8: Sources 1 to 5 are level sensitive. After completion, such a source is pending again one cycle later if its input is still high, and stays idle if its input is low.
- R9: Sources 6 to 10 are edge sensitive, with a rising input setting the pending bit. One rising edge that arrives during service is held and becomes pending at completion. Further edges during that service are dropped.
- R10: The address is split into a space in its top two bits and an index in the low six bits. Space 0 holds the source priorities, indexed by identifier, with data in the low bits. Space 1 holds the context enable masks, where bit i enables source i and bit 0 always reads 0. Space 2 holds the context thresholds. Space 3 holds the context claim words, where a read claims and a write completes. Writes to source index 0 or beyond the source count are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | NUM_SRC | Interrupt requests; bit k belongs to source k+1 |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe; a read of a claim word claims |
| reg_addr | input | ADDR_W | Register address: space in the top two bits, index below |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid in the same cycle as reg_re |
| irq_ctx | output | NUM_CTX | Interrupt line per context |

## Verification
The assertions assume that the register port never raises its read and write strobes in the same cycle. This means a claim and a completion never land on the gateways together. They also assume that the request inputs change only between clock edges. The bench issues one register operation at a time, with an idle cycle after each, and it changes the request vector on falling edges only. The edge tests use requests that stay high for a single cycle, so that each pulse counts as exactly one rising edge.

// File: rtl/intc_pkg.sv
package intc_pkg;

  // register spaces selected by the top two address bits
  localparam logic [1:0] SP_PRIO  = 2'd0;
  localparam logic [1:0] SP_EN    = 2'd1;
  localparam logic [1:0] SP_THR   = 2'd2;
  localparam logic [1:0] SP_CLAIM = 2'd3;

  // a source may be offered to a context only when strictly above its threshold
  function automatic logic f_eligible(input logic pend, input logic en,
                                      input logic [15:0] prio, input logic [15:0] thr);
    return pend && en && (prio > thr);
  endfunction

  // strict compare keeps the earlier (lower) identifier on a tie
  function automatic logic f_beats(input logic [15:0] cand, input logic [15:0] best,
                                   input logic have_best);
    return !have_best || (cand > best);
  endfunction

endpackage

// File: rtl/intc_gateway.sv
module intc_gateway #(
  parameter bit EDGE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_i,
  input  logic claim_i,
  input  logic complete_i,
  output logic pending_o,
  output logic in_service_o
);

  logic prev_q, pend_q, svc_q, defer_q;
  logic rise_w, req_w;
  logic take_claim_w, take_complete_w;

  assign rise_w          = irq_i & ~prev_q;
  assign req_w           = EDGE ? rise_w : irq_i;
  assign take_claim_w    = claim_i && pend_q;
  assign take_complete_w = complete_i && svc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      pend_q  <= 1'b0;
      svc_q   <= 1'b0;
      defer_q <= 1'b0;
    end else begin
      prev_q <= irq_i;
      if (take_claim_w) begin
        pend_q <= 1'b0;
        svc_q  <= 1'b1;
      end else if (take_complete_w) begin
        svc_q   <= 1'b0;
        pend_q  <= defer_q | req_w;
        defer_q <= 1'b0;
      end else if (svc_q) begin
        if (EDGE && rise_w) defer_q <= 1'b1;
      end else if (!pend_q && req_w) begin
        pend_q <= 1'b1;
      end
    end
  end

  assign pending_o    = pend_q;
  assign in_service_o = svc_q;

  // R7: a source in service is never offered again
  a_r7_blocked_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    svc_q |-> !pend_q);

  // R6: an accepted claim moves the source into service
  a_r6_claim_clears: assert property (@(posedge clk) disable iff (!rst_n)
    take_claim_w |=> (svc_q && !pend_q));

  // R8: a level source still asserted is pending again after completion
  a_r8_level_repend: assert property (@(posedge clk) disable iff (!rst_n)
    (take_complete_w && irq_i && !EDGE) |=> pend_q);

  // R9: a held edge exists only while the source is in service
  a_r9_defer_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    defer_q |-> svc_q);

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter import intc_pkg::*; #(
  parameter int NSRC = 10,
  parameter int PW   = 3,
  parameter int IDW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pend_i,
  input  logic [NSRC-1:0] en_i,
  input  logic [PW-1:0]   prio_i [NSRC],
  input  logic [PW-1:0]   thr_i,
  output logic [IDW-1:0]  id_o,
  output logic            valid_o
);

  logic [NSRC-1:0] elig_w;
  logic [PW-1:0]   best_p;

  for (genvar k = 0; k < NSRC; k++) begin : g_elig
    assign elig_w[k] = f_eligible(pend_i[k], en_i[k], 16'(prio_i[k]), 16'(thr_i));
  end

  always_comb begin
    id_o    = '0;
    valid_o = 1'b0;
    best_p  = '0;
    for (int k = 0; k < NSRC; k++) begin
      if (elig_w[k] && f_beats(16'(prio_i[k]), 16'(best_p), valid_o)) begin
        valid_o = 1'b1;
        best_p  = prio_i[k];
        id_o    = IDW'(k + 1);
      end
    end
  end

  // named event for the checks: some eligible source should have won instead
  logic [IDW-1:0] win_idx_w;
  logic           beaten_w;
  assign win_idx_w = id_o - IDW'(1);

  always_comb begin
    beaten_w = 1'b0;
    for (int k = 0; k < NSRC; k++) begin
      if (valid_o && elig_w[k] &&
          ((prio_i[k] > prio_i[win_idx_w]) ||
           ((prio_i[k] == prio_i[win_idx_w]) && (IDW'(k) < win_idx_w))))
        beaten_w = 1'b1;
    end
  end

  // R2: the presented source is one that may reach this context
  a_r2_pick_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> elig_w[win_idx_w]);

  // R3: nothing eligible presents identifier 0
  a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (elig_w == '0) |-> (!valid_o && id_o == '0));

  // R4: no eligible source outranks the winner
  a_r4_best_wins: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> !beaten_w);

endmodule

// File: rtl/intc_core.sv
module intc_core import intc_pkg::*; #(
  parameter int               NUM_SRC  = 10,
  parameter int               NUM_CTX  = 9,
  parameter int               PRIO_W   = 3,
  parameter int               ADDR_W   = 8,
  parameter int               DATA_W   = 32,
  parameter logic [NUM_SRC-1:0] EDGE_SRC = 10'b11_1110_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic               reg_we,
  input  logic               reg_re,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic [NUM_CTX-1:0] irq_ctx
);

  localparam int IDW       = $clog2(NUM_SRC + 1);
  localparam int IDX_W     = ADDR_W - 2;
  localparam int SRC_SEL_W = $clog2(NUM_SRC);
  localparam int CTX_SEL_W = $clog2(NUM_CTX);

  // ---------------- address decode ----------------
  logic [1:0]           space_w;
  logic [IDX_W-1:0]     idx_w;
  logic                 src_hit_w, ctx_hit_w;
  logic [SRC_SEL_W-1:0] src_sel_w;
  logic [CTX_SEL_W-1:0] ctx_sel_w;

  assign space_w   = reg_addr[ADDR_W-1 -: 2];
  assign idx_w     = reg_addr[IDX_W-1:0];
  assign src_hit_w = (idx_w != '0) && (idx_w <= IDX_W'(NUM_SRC));
  assign ctx_hit_w = (idx_w < IDX_W'(NUM_CTX));
  assign src_sel_w = SRC_SEL_W'(idx_w - IDX_W'(1));
  assign ctx_sel_w = CTX_SEL_W'(idx_w);

  // ---------------- configuration storage ----------------
  logic [PRIO_W-1:0]  prio_q [NUM_SRC];
  logic [NUM_SRC-1:0] en_q   [NUM_CTX];
  logic [PRIO_W-1:0]  thr_q  [NUM_CTX];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_SRC; k++) prio_q[k] <= '0;
      for (int c = 0; c < NUM_CTX; c++) begin
        en_q[c]  <= '0;
        thr_q[c] <= '0;
      end
    end else if (reg_we) begin
      case (space_w)
        SP_PRIO: if (src_hit_w) prio_q[src_sel_w] <= reg_wdata[PRIO_W-1:0];
        SP_EN:   if (ctx_hit_w) en_q[ctx_sel_w]   <= reg_wdata[NUM_SRC:1];
        SP_THR:  if (ctx_hit_w) thr_q[ctx_sel_w]  <= reg_wdata[PRIO_W-1:0];
        default: ;
      endcase
    end
  end

  // ---------------- gateways ----------------
  logic [NUM_SRC-1:0] gw_pend_w, gw_svc_w;
  logic [NUM_SRC-1:0] claim_vec_w, complete_vec_w;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_gw
    intc_gateway #(.EDGE(EDGE_SRC[k])) u_gw (
      .clk          (clk),
      .rst_n        (rst_n),
      .irq_i        (irq_src[k]),
      .claim_i      (claim_vec_w[k]),
      .complete_i   (complete_vec_w[k]),
      .pending_o    (gw_pend_w[k]),
      .in_service_o (gw_svc_w[k])
    );
  end

  // ---------------- per-context arbitration ----------------
  logic [IDW-1:0]     arb_id_w [NUM_CTX];
  logic [NUM_CTX-1:0] arb_valid_w;

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    intc_arbiter #(.NSRC(NUM_SRC), .PW(PRIO_W), .IDW(IDW)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .pend_i  (gw_pend_w),
      .en_i    (en_q[c]),
      .prio_i  (prio_q),
      .thr_i   (thr_q[c]),
      .id_o    (arb_id_w[c]),
      .valid_o (arb_valid_w[c])
    );
  end

  assign irq_ctx = arb_valid_w;

  // ---------------- claim / complete events ----------------
  logic           claim_evt_w, complete_evt_w;
  logic [IDW-1:0] sel_id_w;
  logic           sel_valid_w;

  assign claim_evt_w    = reg_re && (space_w == SP_CLAIM) && ctx_hit_w;
  assign complete_evt_w = reg_we && (space_w == SP_CLAIM) && ctx_hit_w;
  assign sel_id_w       = arb_id_w[ctx_sel_w];
  assign sel_valid_w    = arb_valid_w[ctx_sel_w];

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_evt
    assign claim_vec_w[k]    = claim_evt_w && sel_valid_w && (sel_id_w == IDW'(k + 1));
    assign complete_vec_w[k] = complete_evt_w && (reg_wdata == DATA_W'(k + 1));
  end

  // ---------------- read mux ----------------
  always_comb begin
    reg_rdata = '0;
    case (space_w)
      SP_PRIO:  if (src_hit_w) reg_rdata = DATA_W'(prio_q[src_sel_w]);
      SP_EN:    if (ctx_hit_w) reg_rdata = DATA_W'({en_q[ctx_sel_w], 1'b0});
      SP_THR:   if (ctx_hit_w) reg_rdata = DATA_W'(thr_q[ctx_sel_w]);
      default:  if (ctx_hit_w) reg_rdata = DATA_W'(sel_id_w);
    endcase
  end

  // R6: at most one source is claimed at a time
  a_r6_single_claim: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(claim_vec_w));

  // R6: the claimed source is in service on the next cycle
  a_r6_claim_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (|claim_vec_w) |=> ((gw_svc_w & $past(claim_vec_w)) == $past(claim_vec_w)));

  // R7: a completion frees a source that was in service
  a_r7_complete_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (|(complete_vec_w & gw_svc_w)) |=> ((gw_svc_w & $past(complete_vec_w)) == '0));

endmodule

// File: tb/intc_core_bench.sv
module intc_core_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 10;
  localparam int NCTX = 9;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NSRC-1:0]  irq_src;
  logic             reg_we, reg_re;
  logic [7:0]       reg_addr;
  logic [31:0]      reg_wdata;
  logic [31:0]      reg_rdata;
  logic [NCTX-1:0]  irq_ctx;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  intc_core u_intc_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_src   (irq_src),
    .reg_we    (reg_we),
    .reg_re    (reg_re),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_ctx   (irq_ctx)
  );

  // vector: {op[1:0], addr[7:0], data[15:0], exp[15:0], req[7:0]}
  // op 0 write, 1 read and compare, 2 drive irq_src, 3 compare irq_ctx
  localparam int NV = 44;
  localparam logic [49:0] VEC [NV] = '{
    {2'd0, 8'h01, 16'h0003, 16'h0000, 8'd10},  // prio src1 = 3
    {2'd0, 8'h02, 16'h0005, 16'h0000, 8'd10},  // prio src2 = 5
    {2'd0, 8'h03, 16'h0005, 16'h0000, 8'd10},  // prio src3 = 5
    {2'd0, 8'h40, 16'h001E, 16'h0000, 8'd10},  // ctx0 enables src1..4
    {2'd0, 8'h41, 16'h0002, 16'h0000, 8'd10},  // ctx1 enables src1
    {2'd0, 8'h80, 16'h0002, 16'h0000, 8'd10},  // ctx0 threshold 2
    {2'd0, 8'h81, 16'h0003, 16'h0000, 8'd10},  // ctx1 threshold 3
    {2'd2, 8'h00, 16'h0009, 16'h0000, 8'd2},   // src1, src4 high
    {2'd3, 8'h00, 16'h0000, 16'h0001, 8'd3},   // R3: equal threshold masks ctx1
    {2'd1, 8'hC1, 16'h0000, 16'h0000, 8'd3},   // R3: empty claim gives 0
    {2'd2, 8'h00, 16'h000F, 16'h0000, 8'd2},   // src1..4 high
    {2'd3, 8'h00, 16'h0000, 16'h0001, 8'd2},   // R2
    {2'd1, 8'hC0, 16'h0000, 16'h0002, 8'd4},   // R4: tie at 5, lowest id
    {2'd1, 8'hC0, 16'h0000, 16'h0003, 8'd4},   // R4
    {2'd1, 8'hC0, 16'h0000, 16'h0001, 8'd4},   // R4
    {2'd1, 8'hC0, 16'h0000, 16'h0000, 8'd3},   // R3: src4 has priority 0
    {2'd3, 8'h00, 16'h0000, 16'h0000, 8'd7},   // R7: all blocked in service
    {2'd0, 8'hC0, 16'h0005, 16'h0000, 8'd7},   // complete id not in service
    {2'd3, 8'h00, 16'h0000, 16'h0000, 8'd7},   // R7: no effect
    {2'd0, 8'hC0, 16'h0002, 16'h0000, 8'd8},   // complete src2, still high
    {2'd3, 8'h00, 16'h0000, 16'h0001, 8'd8},   // R8: level re-pends
    {2'd1, 8'hC1, 16'h0000, 16'h0000, 8'd5},   // R5: ctx1 sees nothing
    {2'd0, 8'hC0, 16'h0001, 16'h0000, 8'd7},   // complete src1
    {2'd3, 8'h00, 16'h0000, 16'h0001, 8'd5},   // R5: ctx1 still masked
    {2'd0, 8'h81, 16'h0002, 16'h0000, 8'd5},   // ctx1 threshold 2
    {2'd3, 8'h00, 16'h0000, 16'h0003, 8'd5},   // R5: both lines
    {2'd1, 8'hC1, 16'h0000, 16'h0001, 8'd6},   // R6: ctx1 claims src1
    {2'd3, 8'h00, 16'h0000, 16'h0001, 8'd6},   // R6: ctx1 drops, ctx0 keeps src2
    {2'd1, 8'hC0, 16'h0000, 16'h0002, 8'd6},   // R6
    {2'd3, 8'h00, 16'h0000, 16'h0000, 8'd6},   // R6
    {2'd1, 8'h02, 16'h0000, 16'h0005, 8'd10},  // R10 readback
    {2'd1, 8'h40, 16'h0000, 16'h001E, 8'd10},  // R10
    {2'd1, 8'h81, 16'h0000, 16'h0002, 8'd10},  // R10
    {2'd0, 8'h41, 16'h0003, 16'h0000, 8'd10},  // bit0 of mask written
    {2'd1, 8'h41, 16'h0000, 16'h0002, 8'd10},  // R10: bit0 reads 0
    {2'd0, 8'h00, 16'h0007, 16'h0000, 8'd10},  // prio of id 0
    {2'd1, 8'h00, 16'h0000, 16'h0000, 8'd10},  // R10: ignored
    {2'd0, 8'h0B, 16'h0006, 16'h0000, 8'd10},  // prio beyond range
    {2'd1, 8'h0B, 16'h0000, 16'h0000, 8'd10},  // R10: ignored
    {2'd2, 8'h00, 16'h0000, 16'h0000, 8'd8},   // all requests low
    {2'd0, 8'hC0, 16'h0002, 16'h0000, 8'd8},   // complete src2
    {2'd0, 8'hC0, 16'h0003, 16'h0000, 8'd8},   // complete src3
    {2'd0, 8'hC1, 16'h0001, 16'h0000, 8'd8},   // complete src1
    {2'd3, 8'h00, 16'h0000, 16'h0000, 8'd8}    // R8: low level stays idle
  };

  task automatic check(input string what, input int req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic drive_irq(input logic [NSRC-1:0] v);
    @(negedge clk);
    irq_src = v;
  endtask

  task automatic pulse_irq(input logic [NSRC-1:0] v);
    drive_irq(v);
    drive_irq('0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    checks++;
    fails++;
    $display("FAIL watchdog: got hang expected finish");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; reg_we = 1'b0; reg_re = 1'b0;
    reg_addr = '0; reg_wdata = '0; irq_src = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    check("R1 lines after reset", 1, 32'(irq_ctx), 32'h0);
    do_read(8'hC0, rd); check("R1 claim after reset", 1, rd, 32'h0);
    do_read(8'h01, rd); check("R1 priority after reset", 1, rd, 32'h0);
    do_read(8'h40, rd); check("R1 enable after reset", 1, rd, 32'h0);
    do_read(8'h88, rd); check("R1 threshold after reset", 1, rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [7:0]  a;
      logic [15:0] d, e;
      int          rq;
      op = VEC[i][49:48]; a = VEC[i][47:40]; d = VEC[i][39:24];
      e = VEC[i][23:8];   rq = int'(VEC[i][7:0]);
      case (op)
        2'd0: do_write(a, 32'(d));
        2'd1: begin do_read(a, rd); check($sformatf("vector %0d read", i), rq, rd, 32'(e)); end
        2'd2: drive_irq(d[NSRC-1:0]);
        default: begin
          @(negedge clk);
          check($sformatf("vector %0d lines", i), rq, 32'(irq_ctx), 32'(e));
        end
      endcase
    end

    // R9: edge source 7 (irq_src bit 6) routed to context 2
    do_write(8'h07, 32'd4);
    do_write(8'h42, 32'h80);
    pulse_irq(10'h040);
    @(negedge clk);
    check("R9 edge sets pending", 9, 32'(irq_ctx[2]), 32'h1);
    do_read(8'hC2, rd); check("R9 claim edge source", 9, rd, 32'd7);
    pulse_irq(10'h040);
    pulse_irq(10'h040);
    @(negedge clk);
    check("R9 edge held during service", 9, 32'(irq_ctx[2]), 32'h0);
    do_write(8'hC2, 32'd7);
    @(negedge clk);
    check("R9 held edge pending after completion", 9, 32'(irq_ctx[2]), 32'h1);
    do_read(8'hC2, rd); check("R9 second claim", 9, rd, 32'd7);
    do_write(8'hC2, 32'd7);
    @(negedge clk);
    check("R9 extra edge dropped", 9, 32'(irq_ctx[2]), 32'h0);
    // R9: a steady high edge input does not re-pend
    drive_irq(10'h040);
    @(negedge clk);
    do_read(8'hC2, rd); check("R9 claim of steady edge", 9, rd, 32'd7);
    do_write(8'hC2, 32'd7);
    @(negedge clk);
    check("R9 steady high no new request", 9, 32'(irq_ctx[2]), 32'h0);
    drive_irq('0);

    finish_run();
  end

endmodule